// File: doc/BRIEF.md
# DMA Interrupt Status and Control Register Slice

This block is the register slice that sits beside a network DMA engine. Software reaches it through a plain 32-bit register port with a write strobe, an address, write data and a read-data return. The transmit and receive engines signal events as single-cycle pulses. The slice catches each pulse in a sticky status bit, and software clears that bit by writing a one to it. Two summary flags are built over the sticky bits. One covers routine completion events and the other covers error conditions. Each summary has its own enable bit, and together they drive one interrupt line.

The same status word also shows, live, the 3-bit activity codes of the transmit and receive engines and three optional side-module interrupt levels. These fields are read-only and never raise the interrupt. A control word holds a transmit-run bit and a receive-run bit that drive the engines. A write of any value to the poll address produces a one-cycle wake pulse that tells the transmit engine to look again for a descriptor.

Top module: `dmac_irq_csr`

## Requirements
- R1: After a synchronous reset, irq, tx_run, rx_run, tx_poll and reg_rdata are 0. The status word reads 0 apart from its live fields, and the enable and control words read 0.
- R2: A pulse on evt_pulse[i] sets status bit i, and the bit holds until software clears it. The implemented positions are: 0 tx done, 1 tx halted, 2 tx no descriptor, 3 jabber, 4 rx overflow, 5 tx underflow, 6 rx done, 7 rx no buffer, 8 rx halted, 9 rx watchdog, 10 early tx, 13 bus fault, 14 early rx. Pulses on positions 11 and 12 are ignored, and those bits read 0.
- R3: A write to the status word (offset 0x08) clears every implemented bit in 14:0 whose data bit is 1. Bits written with 0 keep their value.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 15 (error summary) is 1 exactly when any of bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 is set.
- R6: Status bit 16 (routine summary) is 1 exactly when any of bits 0, 2, 6 or 14 is set. Writing 1 to bit 15 or bit 16 has no effect of its own.
- R7: Status bits 19:17 show rx_state, bits 22:20 show tx_state and bits 28:26 show opt_irq, all live. Writes do not change them, and they never assert irq. Bits 25:23 and 31:29 read 0.
- R8: The enable word (offset 0x0C) stores only bit 16 (routine enable) and bit 15 (error enable), and its other bits read 0. irq is a register: one cycle after (bit16 AND routine enable) OR (bit15 AND error enable) holds, irq is 1.
- R9: With both enable bits 0, irq is 0 one cycle later, whatever the status bits hold.
- R10: The control word (offset 0x00) holds tx_run at bit 0 and rx_run at bit 1. Each write sets both bits from the data, so either bit can be changed alone by writing back the other bit's current value. The outputs follow in the cycle after the write, and no other address changes them.
- R11: A write of any data to offset 0x04 makes tx_poll 1 for the next cycle only. Back-to-back writes keep it high. The poll offset reads 0.
- R12: reg_rdata is registered and shows, one cycle after reg_addr is presented, the word at that offset as it was before any write in that same cycle. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | 15 | Single-cycle event pulses from the engines, one per status bit 14:0 |
| tx_state | input | 3 | Live transmit activity code |
| rx_state | input | 3 | Live receive activity code |
| opt_irq | input | 3 | Optional side-module interrupt levels |
| irq | output | 1 | Registered interrupt request |
| tx_run | output | 1 | Transmit engine run enable |
| rx_run | output | 1 | Receive engine run enable |
| tx_poll | output | 1 | One-cycle transmit poll wake pulse |

## Verification
A sticky bit that is lost or stuck shows up in the status word on the next read. From the cycle after it goes wrong, it also shows on irq whenever its summary is enabled. A wrong summary mapping or a wrong mask bit changes irq exactly one cycle after the status change. Clear-versus-event priority is visible in the read that follows the colliding cycle. The bench runs a behavioural model alongside the design and compares every output on every clock. Any such fault is therefore caught within one or two cycles of its cause, during both directed and random traffic.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

  localparam int CSR_W = 32;
  localparam int SRC_W = 15;
  localparam int ST_W  = 3;
  localparam int OPT_W = 3;

  // error-class and routine-class source positions within bits 14:0
  localparam logic [SRC_W-1:0] ABN_SRC  = 15'h27BA;
  localparam logic [SRC_W-1:0] NRM_SRC  = 15'h4045;
  localparam logic [SRC_W-1:0] LIVE_SRC = ABN_SRC | NRM_SRC;

  localparam int BIT_AIS = 15;
  localparam int BIT_NIS = 16;
  localparam int RXS_LSB = 17;
  localparam int TXS_LSB = 20;
  localparam int OPT_LSB = 26;

  localparam int CTRL_TX = 0;
  localparam int CTRL_RX = 1;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_POLL = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_IEN  = 'h0C;

  typedef struct packed {
    logic nrm;
    logic abn;
  } ien_t;

endpackage

// File: rtl/dmac_src_latch.sv
module dmac_src_latch
  import dmac_csr_pkg::*;
#(
  parameter int             W    = SRC_W,
  parameter logic [W-1:0]   IMPL = LIVE_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts_q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      logic b_q;

      always_ff @(posedge clk) begin
        if (rst)         b_q <= 1'b0;
        else if (evt[i]) b_q <= 1'b1;
        else if (clr[i]) b_q <= 1'b0;
      end

      assign sts_q[i] = b_q;

      assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (b_q && !clr[i]) |=> b_q)
        else $error("status bit %0d dropped without a clear", i);

      assert_evt_wins_R4: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> b_q)
        else $error("status bit %0d missed an event", i);

      assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && !evt[i]) |=> !b_q)
        else $error("status bit %0d not cleared", i);
    end else begin : g_rsvd
      logic rsvd_unused;
      assign rsvd_unused = evt[i] ^ clr[i];
      assign sts_q[i]    = 1'b0;
    end
  end

endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
  import dmac_csr_pkg::*;
#(
  parameter int DW = CSR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_ien,
  input  logic          wr_poll,
  input  logic [DW-1:0] wdata,
  output logic          tx_go,
  output logic          rx_go,
  output ien_t          ien,
  output logic          poll_pulse
);

  logic dw_unused;
  assign dw_unused = ^{wdata[DW-1:BIT_NIS+1], wdata[BIT_AIS-1:CTRL_RX+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_go <= 1'b0;
      rx_go <= 1'b0;
    end else if (wr_ctrl) begin
      tx_go <= wdata[CTRL_TX];
      rx_go <= wdata[CTRL_RX];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
    end else if (wr_ien) begin
      ien.nrm <= wdata[BIT_NIS];
      ien.abn <= wdata[BIT_AIS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) poll_pulse <= 1'b0;
    else     poll_pulse <= wr_poll;
  end

  assert_ctrl_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> ($stable(tx_go) && $stable(rx_go)))
    else $error("run bits changed without a control write");

  assert_poll_fire_R11: assert property (@(posedge clk) disable iff (rst)
    wr_poll |=> poll_pulse)
    else $error("poll write gave no pulse");

  assert_poll_single_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_poll |=> !poll_pulse)
    else $error("poll pulse without a poll write");

endmodule

// File: rtl/dmac_irq_gen.sv
module dmac_irq_gen
  import dmac_csr_pkg::*;
#(
  parameter int             W   = SRC_W,
  parameter logic [W-1:0]   ABN = ABN_SRC,
  parameter logic [W-1:0]   NRM = NRM_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sts,
  input  ien_t         ien,
  output logic         ais,
  output logic         nis,
  output logic         irq
);

  assign ais = |(sts & ABN);
  assign nis = |(sts & NRM);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (nis && ien.nrm) || (ais && ien.abn);
  end

  assert_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (!ien.nrm && !ien.abn) |=> !irq)
    else $error("irq raised with both enables off");

  assert_abn_fire_R8: assert property (@(posedge clk) disable iff (rst)
    (ien.abn && ais) |=> irq)
    else $error("enabled error summary gave no irq");

  assert_nrm_fire_R8: assert property (@(posedge clk) disable iff (rst)
    (ien.nrm && nis) |=> irq)
    else $error("enabled routine summary gave no irq");

endmodule

// File: rtl/dmac_irq_csr.sv
module dmac_irq_csr
  import dmac_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CSR_W-1:0]  reg_wdata,
  output logic [CSR_W-1:0]  reg_rdata,
  input  logic [SRC_W-1:0]  evt_pulse,
  input  logic [ST_W-1:0]   tx_state,
  input  logic [ST_W-1:0]   rx_state,
  input  logic [OPT_W-1:0]  opt_irq,
  output logic              irq,
  output logic              tx_run,
  output logic              rx_run,
  output logic              tx_poll
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_POLL = ADDR_W'(OFS_POLL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);

  logic             wr_ctrl, wr_ien, wr_poll, wr_stat;
  logic [SRC_W-1:0] clr, sts;
  logic             ais, nis;
  ien_t             ien;
  logic [CSR_W-1:0] stat_word, ien_word, ctrl_word, rd_next;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_poll = reg_wr && (reg_addr == A_POLL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign clr     = wr_stat ? reg_wdata[SRC_W-1:0] : '0;

  dmac_src_latch #(.W(SRC_W), .IMPL(LIVE_SRC)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt_pulse),
    .clr   (clr),
    .sts_q (sts)
  );

  dmac_ctrl_regs #(.DW(CSR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_ctrl    (wr_ctrl),
    .wr_ien     (wr_ien),
    .wr_poll    (wr_poll),
    .wdata      (reg_wdata),
    .tx_go      (tx_run),
    .rx_go      (rx_run),
    .ien        (ien),
    .poll_pulse (tx_poll)
  );

  dmac_irq_gen #(.W(SRC_W), .ABN(ABN_SRC), .NRM(NRM_SRC)) u_irq (
    .clk (clk),
    .rst (rst),
    .sts (sts),
    .ien (ien),
    .ais (ais),
    .nis (nis),
    .irq (irq)
  );

  always_comb begin
    stat_word                     = '0;
    stat_word[SRC_W-1:0]          = sts;
    stat_word[BIT_AIS]            = ais;
    stat_word[BIT_NIS]            = nis;
    stat_word[RXS_LSB +: ST_W]    = rx_state;
    stat_word[TXS_LSB +: ST_W]    = tx_state;
    stat_word[OPT_LSB +: OPT_W]   = opt_irq;

    ien_word                      = '0;
    ien_word[BIT_NIS]             = ien.nrm;
    ien_word[BIT_AIS]             = ien.abn;

    ctrl_word                     = '0;
    ctrl_word[CTRL_TX]            = tx_run;
    ctrl_word[CTRL_RX]            = rx_run;

    if (reg_addr == A_CTRL)      rd_next = ctrl_word;
    else if (reg_addr == A_STAT) rd_next = stat_word;
    else if (reg_addr == A_IEN)  rd_next = ien_word;
    else                         rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  assert_poll_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_POLL) |=> (reg_rdata == '0))
    else $error("poll offset read non-zero");

  assert_live_tx_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_STAT) |=> (reg_rdata[TXS_LSB +: ST_W] == $past(tx_state)))
    else $error("tx activity field not live");

  assert_live_rx_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_STAT) |=> (reg_rdata[RXS_LSB +: ST_W] == $past(rx_state)))
    else $error("rx activity field not live");

endmodule

// File: tb/dmac_irq_csr_bench.sv
module dmac_irq_csr_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [14:0] evt_pulse = '0;
  logic [2:0]  tx_state = '0;
  logic [2:0]  rx_state = '0;
  logic [2:0]  opt_irq = '0;
  logic        irq, tx_run, rx_run, tx_poll;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dmac_irq_csr #(.ADDR_W(8)) u_dmac_irq_csr (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .tx_state  (tx_state),
    .rx_state  (rx_state),
    .opt_irq   (opt_irq),
    .irq       (irq),
    .tx_run    (tx_run),
    .rx_run    (rx_run),
    .tx_poll   (tx_poll)
  );

  // behavioural reference model, updated at each rising edge
  int abn_pos[9] = '{1, 3, 4, 5, 7, 8, 9, 10, 13};
  int nrm_pos[4] = '{0, 2, 6, 14};

  bit [14:0] m_sts;
  bit        m_en_n, m_en_a, m_tx, m_rx, m_irq, m_poll;
  bit [31:0] m_rd;

  function automatic bit is_live(int p);
    foreach (abn_pos[k]) if (abn_pos[k] == p) return 1'b1;
    foreach (nrm_pos[k]) if (nrm_pos[k] == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_ais();
    foreach (abn_pos[k]) if (m_sts[abn_pos[k]]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_nis();
    foreach (nrm_pos[k]) if (m_sts[nrm_pos[k]]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [31:0] v = 0;
    case (a)
      8'h00: begin v[0] = m_tx; v[1] = m_rx; end
      8'h08: begin
        v[14:0] = m_sts; v[15] = m_ais(); v[16] = m_nis();
        v[19:17] = rx_state; v[22:20] = tx_state; v[28:26] = opt_irq;
      end
      8'h0C: begin v[16] = m_en_n; v[15] = m_en_a; end
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sts = 0; m_en_n = 0; m_en_a = 0; m_tx = 0; m_rx = 0;
      m_irq = 0; m_poll = 0; m_rd = 0;
    end else begin
      m_rd   = m_read(reg_addr);
      m_irq  = (m_nis() && m_en_n) || (m_ais() && m_en_a);
      m_poll = reg_wr && (reg_addr == 8'h04);
      if (reg_wr && reg_addr == 8'h00) begin m_tx = reg_wdata[0]; m_rx = reg_wdata[1]; end
      if (reg_wr && reg_addr == 8'h0C) begin m_en_n = reg_wdata[16]; m_en_a = reg_wdata[15]; end
      for (int p = 0; p < 15; p++) begin
        if (is_live(p)) begin
          if (evt_pulse[p]) m_sts[p] = 1'b1;
          else if (reg_wr && reg_addr == 8'h08 && reg_wdata[p]) m_sts[p] = 1'b0;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R8",  "irq vs model",     {31'b0, irq},     {31'b0, m_irq});
    chk("R10", "tx_run vs model",  {31'b0, tx_run},  {31'b0, m_tx});
    chk("R10", "rx_run vs model",  {31'b0, rx_run},  {31'b0, m_rx});
    chk("R11", "tx_poll vs model", {31'b0, tx_poll}, {31'b0, m_poll});
    chk("R12", "rdata vs model",   reg_rdata,        m_rd);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (!rst) compare_all();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a);
    reg_wr = 1'b0; reg_addr = a;
    cyc();
  endtask

  task automatic pulse(logic [14:0] v);
    evt_pulse = v;
    cyc();
    evt_pulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
    chk("R1", "tx_run after reset", {31'b0, tx_run}, 32'h0);
    chk("R1", "rx_run after reset", {31'b0, rx_run}, 32'h0);
    chk("R1", "tx_poll after reset", {31'b0, tx_poll}, 32'h0);
    rd(8'h08); chk("R1", "status after reset", reg_rdata, 32'h0);
    rd(8'h0C); chk("R1", "enable after reset", reg_rdata, 32'h0);

    // R2 R6: routine event capture and summary
    pulse(15'h0001);
    rd(8'h08); chk("R6", "tx done -> routine summary", reg_rdata, 32'h0001_0001);

    // R5: error event
    pulse(15'h0020);
    rd(8'h08); chk("R5", "underflow -> error summary", reg_rdata, 32'h0001_8021);

    // R3: write-1 clear of one bit only
    wr(8'h08, 32'h0000_0001);
    rd(8'h08); chk("R3", "clear bit0 keeps bit5", reg_rdata, 32'h0000_8020);

    // R8: enable both summaries
    wr(8'h0C, 32'h0001_8000);
    rd(8'h0C); chk("R8", "enable readback", reg_rdata, 32'h0001_8000);
    chk("R8", "irq with error enabled", {31'b0, irq}, 32'h1);

    // R9: mask all
    wr(8'h0C, 32'h0000_0000);
    rd(8'h0C); chk("R9", "enable cleared", reg_rdata, 32'h0);
    chk("R9", "irq masked", {31'b0, irq}, 32'h0);

    // R4: event and clear collide
    evt_pulse = 15'h0080;
    wr(8'h08, 32'h0000_0080);
    evt_pulse = '0;
    rd(8'h08); chk("R4", "event beats clear", reg_rdata, 32'h0000_80A0);

    // R3: clear all
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08); chk("R3", "clear all", reg_rdata, 32'h0);

    // R2: reserved positions ignored
    pulse(15'h1800);
    rd(8'h08); chk("R2", "reserved bits stay 0", reg_rdata, 32'h0);

    // R7: live fields, read-only, no irq
    wr(8'h0C, 32'h0001_8000);
    tx_state = 3'd6; rx_state = 3'd4; opt_irq = 3'b101;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08); chk("R7", "live fields", reg_rdata, 32'h1468_0000);
    chk("R7", "optional sources raise no irq", {31'b0, irq}, 32'h0);
    tx_state = 3'd0; rx_state = 3'd0; opt_irq = 3'b000;

    // R10: control bits
    wr(8'h00, 32'h1);
    chk("R10", "tx set alone: tx", {31'b0, tx_run}, 32'h1);
    chk("R10", "tx set alone: rx", {31'b0, rx_run}, 32'h0);
    wr(8'h00, 32'h3);
    chk("R10", "rx set keeps tx", {30'b0, rx_run, tx_run}, 32'h3);
    wr(8'h00, 32'h2);
    chk("R10", "tx cleared keeps rx", {30'b0, rx_run, tx_run}, 32'h2);
    rd(8'h00); chk("R10", "control readback", reg_rdata, 32'h2);

    // R11: poll pulse
    wr(8'h04, 32'h0);
    chk("R11", "poll pulse high", {31'b0, tx_poll}, 32'h1);
    rd(8'h04);
    chk("R11", "poll pulse single", {31'b0, tx_poll}, 32'h0);
    chk("R11", "poll offset reads 0", reg_rdata, 32'h0);

    // R12: unmapped offsets
    rd(8'h10); chk("R12", "unmapped 0x10", reg_rdata, 32'h0);
    rd(8'hFC); chk("R12", "unmapped 0xFC", reg_rdata, 32'h0);

    // mixed random traffic, model compared every cycle
    for (int n = 0; n < 600; n++) begin
      evt_pulse = ($urandom_range(0, 3) == 0) ? 15'($urandom) : 15'h0;
      tx_state  = 3'($urandom);
      rx_state  = 3'($urandom);
      opt_irq   = 3'($urandom);
      reg_wr    = ($urandom_range(0, 2) == 0);
      reg_addr  = 8'($urandom_range(0, 4) * 4);
      reg_wdata = $urandom;
      cyc();
    end
    reg_wr = 1'b0; evt_pulse = '0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule